// File: doc/BRIEF.md
# Serial Slave Hold-Condition Controller

This block is the bit-level front end of a serial-flash style SPI slave. It has a pause pin. Chip select, serial clock, data in, the pause pin and an external busy flag all enter a fast system clock domain through synchronizers. Serial clock edges are found by comparing successive samples. The block works in mode 0. Incoming bits are assembled MSB first into bytes for a command layer. Outgoing bytes are taken from that layer and shifted out on the serial data output, which has its own output enable.

The block decides when a pause begins and when it ends. A pause can only start or finish while the serial clock is low. A request made while the clock is high waits for the next clock-low point. While paused, the output enable is off, clock and data activity is ignored, and the shift state is frozen, so the transfer continues from the same bit afterwards.

If the slave is deselected during a pause, its shift logic is cleared and it enters a locked state. It leaves the locked state only after the pause pin has gone high and chip select has then been driven low again. The busy flag from the program/erase engine is passed through untouched in every state.

Top module: `hold_spi_front`

## Requirements
- R1: While reset is asserted and just after it, `miso_oe_o`, `hold_active_o`, `rx_valid_o` and `busy_o` are all 0.
- R2: Data in is sampled on each rising serial clock edge, MSB first. After every eighth rising edge, `rx_byte_o` takes the assembled byte and `rx_valid_o` is high for exactly one system clock.
- R3: Bit 7 of `tx_byte_i` appears on `miso_o` while the slave is deselected, and again on the falling edge that follows the eighth rising edge. Each other falling edge shifts the next lower bit out. `miso_oe_o` is 1 when the slave is selected and neither paused nor locked.
- R4: A falling edge of `hold_n_i` seen while `cs_n_i` is low and `sclk_i` is low starts the pause: `hold_active_o` goes to 1.
- R5: A falling edge of `hold_n_i` seen while `sclk_i` is high starts the pause only when `sclk_i` next goes low. That falling serial clock edge is still shifted.
- R6: A rising edge of `hold_n_i` while `sclk_i` is low ends the pause at once. While `sclk_i` is high, the end is deferred until `sclk_i` next goes low, and that falling edge is not shifted.
- R7: During a pause, `miso_oe_o` is 0. Serial clock and data transitions change nothing, and the bit position, partial byte and output bit are all kept.
- R8: `busy_o` follows `busy_i` after synchronization in every state, including during a pause.
- R9: Raising `cs_n_i` during a pause clears the shift state and locks the slave. While locked, `miso_oe_o` is 0, no byte is delivered, and no pause starts. The lock ends only once `hold_n_i` and `cs_n_i` are both high, followed by `cs_n_i` going low.
- R10: Raising `cs_n_i` outside a pause resets the bit position, so the next selection starts a fresh byte.
- R11: A falling edge of `hold_n_i` while `cs_n_i` is high does not start a pause, even if `cs_n_i` then goes low with `hold_n_i` still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Pause request, active low |
| busy_i | input | 1 | Program/erase busy flag from the engine |
| tx_byte_i | input | 8 | Next byte to send |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe when a byte completes |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the serial data out |
| hold_active_o | output | 1 | Pause in force |
| busy_o | output | 1 | Synchronized busy flag |

## Verification
Two events can land in the same system clock: a deferred pause change and a serial clock falling edge. On entry, that edge must still shift the output. On exit, it must not. The bench provokes both cases by changing the pause pin while the serial clock is high and then lowering the clock. It judges the result from the output bit seen after the edge and from the byte received once the transfer is finished. A second coincidence, deselection during a pause, is judged by whether the next byte after recovery arrives intact.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  typedef enum logic [2:0] {
    HS_RUN      = 3'd0,
    HS_PEND_IN  = 3'd1,
    HS_HOLD     = 3'd2,
    HS_PEND_OUT = 3'd3,
    HS_LOCK     = 3'd4,
    HS_ARM      = 3'd5
  } hold_state_e;
endpackage

// File: rtl/hsf_sync.sv
module hsf_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_V;
        else if (g == 0) stg_q[g] <= d_i;
        else stg_q[g] <= stg_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hsf_hold_fsm.sv
module hsf_hold_fsm
  import hsf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sclk_s,
  input  logic hold_s,
  output logic run_en_o,
  output logic held_o,
  output logic lock_o
);
  hold_state_e st_q, st_d;
  logic        hold_q;
  logic        hold_fall;

  assign hold_fall = hold_q & ~hold_s;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_RUN: begin
        if (!cs_s && hold_fall) st_d = sclk_s ? HS_PEND_IN : HS_HOLD;
      end
      HS_PEND_IN: begin
        if (cs_s || hold_s) st_d = HS_RUN;
        else if (!sclk_s)   st_d = HS_HOLD;
      end
      HS_HOLD: begin
        if (cs_s)        st_d = HS_LOCK;
        else if (hold_s) st_d = sclk_s ? HS_PEND_OUT : HS_RUN;
      end
      HS_PEND_OUT: begin
        if (cs_s)         st_d = HS_LOCK;
        else if (!hold_s) st_d = HS_HOLD;
        else if (!sclk_s) st_d = HS_RUN;
      end
      HS_LOCK: begin
        if (cs_s && hold_s) st_d = HS_ARM;
      end
      HS_ARM: begin
        if (!hold_s)    st_d = HS_LOCK;
        else if (!cs_s) st_d = HS_RUN;
      end
      default: st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_RUN;
      hold_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_s;
    end
  end

  assign run_en_o = (st_q == HS_RUN) || (st_q == HS_PEND_IN);
  assign held_o   = (st_q == HS_HOLD) || (st_q == HS_PEND_OUT);
  assign lock_o   = (st_q == HS_LOCK) || (st_q == HS_ARM);
endmodule

// File: rtl/hsf_shifter.sv
module hsf_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_en_i,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] tx_byte_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o,
  output logic          miso_o
);
  localparam int            CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  logic          sclk_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_sr_q, rx_sr_d;
  logic [DW-1:0] tx_sr_q, tx_sr_d;
  logic [DW-1:0] rx_byte_q, rx_byte_d;
  logic          valid_q, valid_d;
  logic          rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  always_comb begin
    cnt_d     = cnt_q;
    rx_sr_d   = rx_sr_q;
    tx_sr_d   = tx_sr_q;
    rx_byte_d = rx_byte_q;
    valid_d   = 1'b0;
    if (clear_i) begin
      cnt_d   = '0;
      rx_sr_d = '0;
      tx_sr_d = tx_byte_i;
    end else if (run_en_i) begin
      if (rise) begin
        rx_sr_d = {rx_sr_q[DW-2:0], mosi_s};
        if (cnt_q == LAST) begin
          cnt_d     = '0;
          rx_byte_d = {rx_sr_q[DW-2:0], mosi_s};
          valid_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (fall) begin
        if (cnt_q == '0) tx_sr_d = tx_byte_i;
        else             tx_sr_d = {tx_sr_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cnt_q     <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
      rx_byte_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      cnt_q     <= cnt_d;
      rx_sr_q   <= rx_sr_d;
      tx_sr_q   <= tx_sr_d;
      rx_byte_q <= rx_byte_d;
      valid_q   <= valid_d;
    end
  end

  assign rx_byte_o  = rx_byte_q;
  assign rx_valid_o = valid_q;
  assign miso_o     = tx_sr_q[DW-1];
endmodule

// File: rtl/hold_spi_front.sv
module hold_spi_front #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          sclk_i,
  input  logic          mosi_i,
  input  logic          hold_n_i,
  input  logic          busy_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          hold_active_o,
  output logic          busy_o
);
  localparam int NSIG = 5;

  logic [1:0]      rst_sr_q;
  logic            rst_int_n;
  logic [NSIG-1:0] raw, syn;
  logic            cs_s, sclk_s, mosi_s, hold_s, busy_s;
  logic            run_en, held, lock_w, clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= 2'b00;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_int_n = rst_sr_q[1];

  assign raw = {busy_i, hold_n_i, mosi_i, sclk_i, cs_n_i};

  hsf_sync #(
    .W      (NSIG),
    .STAGES (SYNC_STAGES),
    .RST_V  (5'b01001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign cs_s   = syn[0];
  assign sclk_s = syn[1];
  assign mosi_s = syn[2];
  assign hold_s = syn[3];
  assign busy_s = syn[4];

  hsf_hold_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_s     (cs_s),
    .sclk_s   (sclk_s),
    .hold_s   (hold_s),
    .run_en_o (run_en),
    .held_o   (held),
    .lock_o   (lock_w)
  );

  assign clear = cs_s | lock_w;

  hsf_shifter #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (clear),
    .run_en_i   (run_en),
    .sclk_s     (sclk_s),
    .mosi_s     (mosi_s),
    .tx_byte_i  (tx_byte_i),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .miso_o     (miso_o)
  );

  assign miso_oe_o     = ~cs_s & run_en;
  assign hold_active_o = held;
  assign busy_o        = busy_s;
endmodule

// File: rtl/hold_spi_front_chk.sv
module hold_spi_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_active,
  input logic          oe,
  input logic          rx_valid,
  input logic [DW-1:0] rx_byte,
  input logic          miso,
  input logic          locked
);
  AST_OE_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !oe); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2
  AST_NO_BYTE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_active) |-> !rx_valid); // R7
  AST_RX_KEPT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && $past(hold_active)) |-> $stable(rx_byte)); // R7
  AST_MISO_KEPT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && $past(hold_active)) |-> $stable(miso)); // R7
  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!oe && !hold_active)); // R9
  AST_LOCK_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> !rx_valid); // R9
endmodule

bind hold_spi_front hold_spi_front_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_active (hold_active_o),
  .oe          (miso_oe_o),
  .rx_valid    (rx_valid_o),
  .rx_byte     (rx_byte_o),
  .miso        (miso_o),
  .locked      (lock_w)
);

// File: tb/test_hold_spi_front.sv
module test_hold_spi_front;
  localparam int HALF = 6;
  localparam int NV   = 6;
  // {rx byte, tx byte, bit index where a pause is inserted (8 = none)}
  localparam logic [19:0] VEC [NV] = '{
    {8'hA5, 8'h3C, 4'd0},
    {8'h5A, 8'hC3, 4'd3},
    {8'hFF, 8'h81, 4'd7},
    {8'h00, 8'h7E, 4'd8},
    {8'h96, 8'hE1, 4'd5},
    {8'h1B, 8'h42, 4'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, sclk, mosi, hold_n, busy;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic       rx_valid, miso, miso_oe, hold_active, busy_o;

  int n_run  = 0;
  int n_fail = 0;
  int valid_cnt = 0;
  int dbl_valid = 0;
  logic [7:0] last_rx = '0;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hold_spi_front i_hold_spi_front (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n_i        (cs_n),
    .sclk_i        (sclk),
    .mosi_i        (mosi),
    .hold_n_i      (hold_n),
    .busy_i        (busy),
    .tx_byte_i     (tx_byte),
    .rx_byte_o     (rx_byte),
    .rx_valid_o    (rx_valid),
    .miso_o        (miso),
    .miso_oe_o     (miso_oe),
    .hold_active_o (hold_active),
    .busy_o        (busy_o)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      valid_cnt = valid_cnt + 1;
      last_rx   = rx_byte;
      if (prev_valid) dbl_valid = dbl_valid + 1;
    end
    prev_valid = rx_valid;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    mosi = b; w(HALF);
    sclk = 1'b1; w(HALF);
    sclk = 1'b0; w(HALF);
  endtask

  task automatic select(input logic [7:0] tx);
    cs_n = 1'b1; tx_byte = tx; w(HALF);
    cs_n = 1'b0; w(HALF);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  initial begin
    #(20 * 200000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int vc;
    logic [7:0] d, t;
    int k;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    hold_n = 1'b1; busy = 1'b0; tx_byte = 8'h00;
    w(3);
    chk(!miso_oe && !hold_active && !rx_valid && !busy_o, "R1 in reset",
        {miso_oe, hold_active, rx_valid, busy_o}, 0);
    rst_n = 1'b1; w(6);
    chk(!miso_oe && !hold_active && !rx_valid && !busy_o, "R1 after reset",
        {miso_oe, hold_active, rx_valid, busy_o}, 0);

    // vector walk: byte transfers with a pause at a chosen bit
    for (int v = 0; v < NV; v++) begin
      d = VEC[v][19:12]; t = VEC[v][11:4]; k = int'(VEC[v][3:0]);
      select(t);
      chk(miso_oe == 1'b1, "R3 oe when selected", miso_oe, 1);
      vc = valid_cnt;
      for (int i = 0; i < 8; i++) begin
        if (i == k) begin
          hold_n = 1'b0; w(HALF);
          chk(hold_active == 1'b1, "R4 pause at clock low", hold_active, 1);
          chk(miso_oe == 1'b0, "R7 oe off in pause", miso_oe, 0);
          mosi = ~mosi; sclk = 1'b1; w(HALF);
          sclk = 1'b0; w(HALF);
          mosi = ~mosi; sclk = 1'b1; w(HALF);
          sclk = 1'b0; w(HALF);
          chk(valid_cnt == vc, "R7 no byte in pause", valid_cnt, vc);
          hold_n = 1'b1; w(HALF);
          chk(hold_active == 1'b0, "R6 release at clock low", hold_active, 0);
        end
        chk(miso == t[7-i], "R3 R7 output bit", miso, t[7-i]);
        bit_out(d[7-i]);
      end
      w(2);
      chk(valid_cnt == vc + 1, "R2 one strobe per byte", valid_cnt, vc + 1);
      chk(last_rx == d, "R2 R7 received byte", last_rx, d);
      chk(miso == t[7], "R3 reload after byte", miso, t[7]);
      cs_n = 1'b1; w(HALF);
    end
    chk(dbl_valid == 0, "R2 strobe width", dbl_valid, 0);

    // R5 / R6: deferred entry and exit meet a falling clock edge
    d = 8'hC6; t = 8'hB4;
    select(t);
    vc = valid_cnt;
    bit_out(d[7]); bit_out(d[6]);
    mosi = d[5]; w(HALF);
    sclk = 1'b1; w(HALF);
    hold_n = 1'b0; w(HALF);
    chk(hold_active == 1'b0, "R5 entry deferred while clock high", hold_active, 0);
    sclk = 1'b0; w(HALF);
    chk(hold_active == 1'b1, "R5 entry at clock fall", hold_active, 1);
    chk(miso == t[4], "R5 entering edge still shifts", miso, t[4]);
    busy = 1'b1; w(HALF);
    chk(busy_o == 1'b1, "R8 busy passes in pause", busy_o, 1);
    sclk = 1'b1; w(HALF);
    hold_n = 1'b1; w(HALF);
    chk(hold_active == 1'b1, "R6 exit deferred while clock high", hold_active, 1);
    busy = 1'b0; w(HALF);
    chk(busy_o == 1'b0, "R8 busy clears in pause", busy_o, 0);
    sclk = 1'b0; w(HALF);
    chk(hold_active == 1'b0, "R6 exit at clock fall", hold_active, 0);
    chk(miso == t[4], "R6 leaving edge not shifted", miso, t[4]);
    for (int i = 3; i < 8; i++) begin
      chk(miso == t[7-i], "R6 resumed output bit", miso, t[7-i]);
      bit_out(d[7-i]);
    end
    w(2);
    chk(last_rx == d && valid_cnt == vc + 1, "R5 R6 byte intact", last_rx, d);
    cs_n = 1'b1; w(HALF);

    // R9: deselect during pause locks the slave
    d = 8'h3D;
    select(8'h99);
    vc = valid_cnt;
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    hold_n = 1'b0; w(HALF);
    chk(hold_active == 1'b1, "R4 pause before deselect", hold_active, 1);
    cs_n = 1'b1; w(HALF);
    chk(hold_active == 1'b0 && miso_oe == 1'b0, "R9 locked after deselect",
        {hold_active, miso_oe}, 0);
    cs_n = 1'b0; w(HALF);
    chk(miso_oe == 1'b0, "R9 reselect while pause low stays silent", miso_oe, 0);
    hold_n = 1'b1; w(HALF);
    hold_n = 1'b0; w(HALF);
    chk(hold_active == 1'b0, "R9 no pause while locked", hold_active, 0);
    hold_n = 1'b1; w(HALF);
    byte_out(8'hE7);
    w(2);
    chk(valid_cnt == vc, "R9 no byte while locked", valid_cnt, vc);
    chk(miso_oe == 1'b0, "R9 still locked", miso_oe, 0);
    select(8'h5C);
    chk(miso_oe == 1'b1, "R9 recovery after pause high then select", miso_oe, 1);
    byte_out(d);
    w(2);
    chk(last_rx == d && valid_cnt == vc + 1, "R9 bit count cleared", last_rx, d);
    cs_n = 1'b1; w(HALF);

    // R10: deselect mid-byte without a pause
    d = 8'h6E;
    select(8'h00);
    vc = valid_cnt;
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    select(8'h00);
    byte_out(d);
    w(2);
    chk(last_rx == d && valid_cnt == vc + 1, "R10 fresh byte after deselect", last_rx, d);

    // R11: pause edge while deselected is ignored
    cs_n = 1'b1; w(HALF);
    hold_n = 1'b0; w(HALF);
    cs_n = 1'b0; w(HALF);
    chk(hold_active == 1'b0, "R11 no pause from deselected edge", hold_active, 0);
    chk(miso_oe == 1'b1, "R11 output enabled", miso_oe, 1);
    hold_n = 1'b1; cs_n = 1'b1; w(HALF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule